// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the master side of a link to a serial analog-to-digital converter. It is started by a one-cycle request. The block then drives the active-low start-conversion line low for a set number of cycles. While the conversion runs it holds the serial clock low. It detects the end of conversion in one of two ways, picked per request: it watches the converter's busy line fall, or, where busy is not wired, it waits a fixed number of cycles counted from the start of conversion.

The block then raises a device-select output and produces exactly 16 serial clock pulses. The clock idles low and is only let out while select is high, so the pin carries the AND of the internal clock and the select bit. Several converters can share one clock line this way. Data is sampled on the falling edge of each pulse, most significant bit first. The two leading bits are dropped and checked for zero. The remaining 14 bits are returned, either as received or bit-reversed, with a one-cycle valid strobe.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, conv_n is 1, sclk is 0, dev_sel is 0 and result_valid is 0.
- R2: A start_req seen in idle drives conv_n low for exactly CONV_PULSE clock cycles, where CONV_PULSE is at least 2*DIV_HALF.
- R3: sclk is 0 in every cycle in which conv_n is 0.
- R4: With wait_on_busy=1 latched at start, no sclk rising edge occurs while busy is 1, and the read starts the cycle after busy is sampled 0.
- R5: With wait_on_busy=0, busy is ignored, and result_valid rises CONV_WAIT + 32*DIV_HALF cycles after the clock edge that samples start_req.
- R6: Each read produces exactly 16 sclk pulses, each high for DIV_HALF cycles and low for DIV_HALF cycles.
- R7: sdata is sampled on each sclk falling edge. With lsb_first=0 latched at start, result[13] is the 3rd bit received and result[0] the 16th.
- R8: With lsb_first=1 latched at start, result[0] is the 3rd bit received and result[13] the 16th.
- R9: lead_err is 1 when either of the first two received bits is 1, and 0 otherwise.
- R10: result_valid is high for exactly one cycle per read, and result and lead_err hold their values until the next read completes.
- R11: start_req while a conversion, wait or read is in progress is ignored: it makes no conv_n pulse and no result.
- R12: dev_sel is 1 only during the 16-pulse read, and sclk is never 1 while dev_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to convert and read |
| wait_on_busy | input | 1 | 1: end of conversion from busy; 0: fixed wait |
| lsb_first | input | 1 | 1: return result bit-reversed |
| busy | input | 1 | Converter busy, synchronous to clk |
| sdata | input | 1 | Serial data from converter |
| conv_n | output | 1 | Active-low start of conversion |
| sclk | output | 1 | Gated serial clock to converter |
| dev_sel | output | 1 | Device select, high during read |
| result | output | 14 | Conversion result |
| result_valid | output | 1 | One-cycle result strobe |
| lead_err | output | 1 | A leading bit was nonzero |

## Verification
In fixed-wait mode the strobe is due exactly CONV_WAIT + 32*DIV_HALF cycles after the edge that samples the request. In busy mode it is due busy-model length + 3 + 32*DIV_HALF cycles after that edge, counting the model's one-edge detect, its countdown and the controller's busy sample. The driver stamps each request with the edge number that takes it and queues that stamp with the expected result. The monitor samples on falling clock edges and compares the edge number of each strobe with the stamp. Pulse widths and pulse counts are measured by the bench from the pins. The result is rechecked after the strobe to confirm that it holds.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_READ
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
// Serial clock generator: low half then high half, NBITS pulses while en.
module adc_rd_sclk_gen #(
  parameter int DIV_HALF = 4,
  parameter int NBITS    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sclk,
  output logic cap,
  output logic last
);
  localparam int HW = $clog2(DIV_HALF + 1);
  localparam int BW = $clog2(NBITS + 1);

  logic [HW-1:0] hc;
  logic [BW-1:0] bcnt;
  logic          ph;
  logic          half_end;

  assign half_end = en && (hc == HW'(DIV_HALF - 1));
  assign cap      = half_end && ph;
  assign last     = cap && (bcnt == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hc   <= '0;
      ph   <= 1'b0;
      bcnt <= '0;
      sclk <= 1'b0;
    end else if (half_end) begin
      hc   <= '0;
      ph   <= !ph;
      sclk <= !ph;
      if (ph) bcnt <= bcnt + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
// Shifts in sampled bits, strips leading bits, optional bit reversal.
module adc_rd_capture #(
  parameter int NBITS = 16,
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic             last,
  input  logic             sdata,
  input  logic             lsb_first,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             lead_err
);
  logic [NBITS-2:0] sh;
  logic [NBITS-1:0] word;
  logic [RES_W-1:0] rev;

  assign word = {sh, sdata};

  for (genvar i = 0; i < RES_W; i++) begin : g_rev
    assign rev[i] = word[RES_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh           <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      lead_err     <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (cap) sh <= word[NBITS-2:0];
      if (last) begin
        result       <= lsb_first ? rev : word[RES_W-1:0];
        lead_err     <= |word[NBITS-1:RES_W];
        result_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DIV_HALF   = 4,
  parameter int CONV_PULSE = 8,
  parameter int CONV_WAIT  = 625,
  parameter int NBITS      = 16,
  parameter int RES_W      = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             wait_on_busy,
  input  logic             lsb_first,
  input  logic             busy,
  input  logic             sdata,
  output logic             conv_n,
  output logic             sclk,
  output logic             dev_sel,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             lead_err
);
  import adc_rd_pkg::*;

  localparam int CW = $clog2(CONV_WAIT + 2);

  rd_state_e      st;
  logic [CW-1:0]  cnt;
  logic           mode_q;
  logic           lsb_q;
  logic           cap;
  logic           last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      conv_n  <= 1'b1;
      dev_sel <= 1'b0;
      mode_q  <= 1'b0;
      lsb_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_req) begin
            st     <= ST_CONV;
            cnt    <= '0;
            conv_n <= 1'b0;
            mode_q <= wait_on_busy;
            lsb_q  <= lsb_first;
          end
        end
        ST_CONV: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CONV_PULSE - 1)) begin
            conv_n <= 1'b1;
            st     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          if (mode_q ? !busy : (cnt == CW'(CONV_WAIT - 1))) begin
            st      <= ST_READ;
            dev_sel <= 1'b1;
          end
        end
        ST_READ: begin
          if (last) begin
            st      <= ST_IDLE;
            dev_sel <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  adc_rd_sclk_gen #(
    .DIV_HALF(DIV_HALF),
    .NBITS   (NBITS)
  ) u_sclk (
    .clk (clk),
    .rst (rst),
    .en  (dev_sel),
    .sclk(sclk),
    .cap (cap),
    .last(last)
  );

  adc_rd_capture #(
    .NBITS(NBITS),
    .RES_W(RES_W)
  ) u_cap (
    .clk         (clk),
    .rst         (rst),
    .cap         (cap),
    .last        (last),
    .sdata       (sdata),
    .lsb_first   (lsb_q),
    .result      (result),
    .result_valid(result_valid),
    .lead_err    (lead_err)
  );
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int DIV_HALF   = 4,
  parameter int CONV_PULSE = 8
) (
  input logic clk,
  input logic rst,
  input logic conv_n,
  input logic sclk,
  input logic dev_sel,
  input logic result_valid
);
  logic [31:0] low_cnt;
  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      low_cnt <= conv_n ? 32'd0 : low_cnt + 1;
      hi_cnt  <= sclk ? hi_cnt + 1 : 32'd0;
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_n) |-> low_cnt == 32'(CONV_PULSE));

  assert_quiet_conv_R3: assert property (@(posedge clk) disable iff (rst)
    !conv_n |-> !sclk);

  assert_sclk_high_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> hi_cnt == 32'(DIV_HALF));

  assert_single_valid_R10: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
    dev_sel |-> conv_n);

  assert_gated_clock_R12: assert property (@(posedge clk) disable iff (rst)
    sclk |-> dev_sel);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .DIV_HALF  (DIV_HALF),
  .CONV_PULSE(CONV_PULSE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .conv_n      (conv_n),
  .sclk        (sclk),
  .dev_sel     (dev_sel),
  .result_valid(result_valid)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
  localparam int DH = 2;
  localparam int CP = 4;
  localparam int CWT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, wait_on_busy = 1'b0, lsb_first = 1'b0;
  logic busy = 1'b0, sdata = 1'b0;
  logic conv_n, sclk, dev_sel, result_valid, lead_err;
  logic [13:0] result;

  always #4 clk = !clk;

  adc_rd_ctrl #(.DIV_HALF(DH), .CONV_PULSE(CP), .CONV_WAIT(CWT)) u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .wait_on_busy(wait_on_busy),
    .lsb_first(lsb_first), .busy(busy), .sdata(sdata), .conv_n(conv_n),
    .sclk(sclk), .dev_sel(dev_sel), .result(result),
    .result_valid(result_valid), .lead_err(lead_err));

  int total = 0, bad = 0;
  int cyc = 0;
  logic [14:0] exp_q[$];
  int          t0_q[$];
  int          lat_q[$];
  int          popped = 0;
  logic [14:0] last_exp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // converter model
  logic [15:0] nxt_word = '0, dev_word = '0;
  int idx = 15, busy_len = 10, busy_cnt = 0;
  logic conv_q = 1'b1;
  always @(posedge clk) begin
    conv_q <= conv_n;
    if (conv_q && !conv_n) begin
      dev_word <= nxt_word;
      idx      <= 15;
      busy     <= 1'b1;
      busy_cnt <= busy_len;
    end else if (busy) begin
      if (busy_cnt == 0) busy <= 1'b0;
      else busy_cnt <= busy_cnt - 1;
    end
  end
  always @(posedge sclk) begin
    sdata <= dev_word[idx];
    idx   <= idx - 1;
  end

  // pin observers
  int conv_falls = 0, rises = 0, busy_viol = 0, gate_viol = 0, conv_viol = 0;
  int low_run = 0, last_low = 0, vrun = 0, vmax = 0;
  int hi_run = 0, lo_run = 0, bad_hi = 0, bad_lo = 0;
  always @(negedge conv_n) conv_falls++;
  always @(posedge sclk) begin
    rises++;
    if (busy && wait_on_busy) busy_viol++;
  end
  always @(negedge clk) if (!rst) begin
    if (sclk && !dev_sel) gate_viol++;
    if (sclk && !conv_n) conv_viol++;
    if (!conv_n) low_run++;
    else if (low_run != 0) begin last_low = low_run; low_run = 0; end
    if (result_valid) vrun++;
    else begin if (vrun > vmax) vmax = vrun; vrun = 0; end
    if (sclk) begin
      if (lo_run != 0 && lo_run != DH && hi_run != 0) bad_lo++;
      lo_run = 0; hi_run++;
    end else begin
      if (hi_run != 0 && hi_run != DH) bad_hi++;
      if (hi_run != 0) lo_run = 0;
      hi_run = 0;
      if (dev_sel) lo_run++;
    end
  end

  // monitor
  always @(negedge clk) if (!rst && result_valid) begin
    if (exp_q.size() == 0) chk(0, "R11 unexpected result", 1, 0);
    else begin
      logic [14:0] e;
      int t0, lat;
      e = exp_q.pop_front();
      t0 = t0_q.pop_front();
      lat = lat_q.pop_front();
      last_exp = e;
      chk(result == e[13:0], "R7/R8 result", result, e[13:0]);
      chk(lead_err == e[14], "R9 lead_err", lead_err, e[14]);
      if (lat >= 0) chk(cyc - t0 == lat, "R4/R5 latency", cyc - t0, lat);
      popped++;
    end
  end

  function automatic logic [13:0] rev14(input logic [13:0] d);
    logic [13:0] r;
    for (int i = 0; i < 14; i++) r[i] = d[13-i];
    return r;
  endfunction

  task automatic do_read(input bit bmode, input bit lsb, input logic [1:0] lead,
                         input logic [13:0] d, input bit poke);
    int target, f0;
    nxt_word = {lead, d};
    wait_on_busy = bmode;
    lsb_first = lsb;
    rises = 0;
    f0 = conv_falls;
    target = popped + 1;
    @(negedge clk);
    start_req = 1'b1;
    exp_q.push_back({|lead, lsb ? rev14(d) : d});
    t0_q.push_back(cyc + 1);
    lat_q.push_back(bmode ? busy_len + 3 + 32*DH : CWT + 32*DH);
    @(negedge clk);
    start_req = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;   // during conversion
      repeat (50) @(negedge clk);
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;   // during read
      lsb_first = !lsb;
    end
    while (popped < target) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(result == last_exp[13:0], "R10 result held", result, last_exp[13:0]);
    chk(rises == 16, "R6 pulse count", rises, 16);
    chk(last_low == CP, "R2 conv_n width", last_low, CP);
    chk(conv_falls - f0 == 1, "R11 conv pulses", conv_falls - f0, 1);
    chk(!dev_sel && !sclk, "R12 idle after read", dev_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(conv_n == 1'b1, "R1 conv_n", conv_n, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(dev_sel == 1'b0, "R1 dev_sel", dev_sel, 0);
    chk(result_valid == 1'b0, "R1 valid", result_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(conv_n && !sclk && !dev_sel && !result_valid, "R1 after reset", 0, 0);

    do_read(0, 0, 2'b00, 14'h2A5C, 0);   // R5 R7
    do_read(0, 1, 2'b00, 14'h0013, 0);   // R8
    busy_len = 60;
    do_read(1, 0, 2'b00, 14'h3FFF, 0);   // R4
    busy_len = 10;
    do_read(0, 0, 2'b10, 14'h1234, 0);   // R9
    do_read(0, 1, 2'b01, 14'h0001, 0);   // R9 R8
    do_read(0, 0, 2'b00, 14'h0000, 1);   // R11
    do_read(1, 1, 2'b00, 14'h2001, 1);   // R11 R4
    repeat (100) @(negedge clk);

    chk(busy_viol == 0, "R4 sclk while busy", busy_viol, 0);
    chk(conv_viol == 0, "R3 sclk during conv", conv_viol, 0);
    chk(gate_viol == 0, "R12 sclk without select", gate_viol, 0);
    chk(bad_hi == 0, "R6 high width", bad_hi, 0);
    chk(bad_lo == 0, "R6 low width", bad_lo, 0);
    chk(vmax == 1, "R10 strobe width", vmax, 1);
    chk(exp_q.size() == 0, "R11 missing results", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule